// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit-data CPU with a 16-bit address bus and the set of memories and peripherals that share that bus. For each access it names exactly one responder: main RAM, one of three ROM windows (an interpreter ROM, a system ROM and a character-glyph ROM), or one of the windows inside an I/O area. The I/O windows are video, sound, color RAM and two peripheral blocks. When the access lands in a peripheral window, the block also supplies the local register offset, with the aliasing that window applies. It then steers the read data of the selected responder back to the CPU.

Which windows are visible is set by a byte register held inside the block at address 0x0001. The low three bits of that byte form a banking code that turns the ROM and I/O windows on or off. A peripheral writes only when it is selected and the CPU's write strobe is high. ROM windows are visible to reads only, so a write under a ROM always falls through to RAM.

Top module: `mem_map_decoder`

## Requirements
- R1: After reset the banking register holds 0x37, so a read of 0x0001 returns 0x37 and banking code 7 is in force.
- R2: With banking code 0 or 4, every address other than 0x0001 selects RAM, for both reads and writes.
- R3: The interpreter ROM is selected for reads of 0xA000–0xBFFF exactly when the code is 3 or 7.
- R4: The system ROM is selected for reads of 0xE000–0xFFFF exactly when the code is 2, 3, 6 or 7.
- R5: The character ROM is selected for reads of 0xD000–0xDFFF exactly when the code is 1, 2 or 3.
- R6: With code 5, 6 or 7, I/O replaces 0xD000–0xDFFF for reads and writes. 0xD000–0xD3FF selects video with offset addr[5:0], so the registers repeat every 64 bytes.
- R7: Inside I/O, 0xD400–0xD7FF selects sound with offset addr[7:0], and 0xD800–0xDBFF selects color RAM with offset addr[9:0].
- R8: Inside I/O, 0xDC00–0xDCFF selects peripheral A and 0xDD00–0xDDFF selects peripheral B, each with offset addr[3:0].
- R9: Inside I/O, 0xDE00–0xDFFF selects the open target. A read there returns 0xFF, and no RAM or peripheral is selected.
- R10: A write to any ROM window selects RAM, not the ROM.
- R11: A write to 0x0001 stores the whole byte at the clock edge, and later reads of 0x0001 return it. Its low three bits become the banking code from the next cycle on. Neither a read nor a write of 0x0001 selects RAM.
- R12: Exactly one select bit is high in every cycle. The bit order is RAM=0, interpreter ROM=1, system ROM=2, character ROM=3, video=4, sound=5, color=6, peripheral A=7, peripheral B=8, banking register=9, open=10. The offset is zero for non-I/O targets, and rdata equals the selected target's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU address |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 8 | CPU write data |
| ram_rdata | input | 8 | Read data from main RAM |
| basic_rdata | input | 8 | Read data from the interpreter ROM |
| sysrom_rdata | input | 8 | Read data from the system ROM |
| chrom_rdata | input | 8 | Read data from the character ROM |
| video_rdata | input | 8 | Read data from the video block |
| sound_rdata | input | 8 | Read data from the sound block |
| color_rdata | input | 8 | Read data from color RAM |
| pera_rdata | input | 8 | Read data from peripheral A |
| perb_rdata | input | 8 | Read data from peripheral B |
| sel | output | 11 | One-hot target select, bit order as in R12 |
| reg_ofs | output | 10 | Local offset for I/O targets, zero otherwise |
| rdata | output | 8 | Read data returned to the CPU |

## Verification
The hardest case to reach is a banking change that takes effect on the very next access. A write to 0x0001 has to land, and the following cycle has to probe a window whose visibility has just flipped. Random stimulus writes random bytes to 0x0001 often. The address generator is weighted toward the three ROM ranges, the I/O sub-windows and the open range, so every code meets every window. Directed sweeps then step through all eight codes in turn, with mirrored I/O addresses and writes under ROM.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
   localparam int NUM_TGT = 11;

   typedef enum logic [3:0] {
      TG_RAM   = 4'd0,
      TG_BASIC = 4'd1,
      TG_SYS   = 4'd2,
      TG_CHR   = 4'd3,
      TG_VID   = 4'd4,
      TG_SND   = 4'd5,
      TG_COL   = 4'd6,
      TG_PA    = 4'd7,
      TG_PB    = 4'd8,
      TG_BREG  = 4'd9,
      TG_OPEN  = 4'd10
   } tgt_e;

   typedef struct packed {
      logic basic;
      logic sys;
      logic chr;
      logic io;
   } vis_t;

   function automatic vis_t code_to_vis(input logic [2:0] code);
      vis_t v;
      v.basic = (code == 3'd3) || (code == 3'd7);
      v.sys   = (code == 3'd2) || (code == 3'd3) || (code == 3'd6) || (code == 3'd7);
      v.chr   = (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
      v.io    = (code == 3'd5) || (code == 3'd6) || (code == 3'd7);
      return v;
   endfunction
endpackage

// File: rtl/mmd_bank_reg.sv
module mmd_bank_reg
   import mmd_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter logic [7:0]  RESET_VAL = 8'h37
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q,
   output vis_t              vis
);
   generate
      if (DATA_W < 3) begin : g_bad_w
         $error("mmd_bank_reg: DATA_W must hold a 3-bit code");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= DATA_W'(RESET_VAL);
      else if (wr_hit)
         q <= wr_data;
   end

   assign vis = code_to_vis(q[2:0]);
endmodule

// File: rtl/mmd_region_decode.sv
module mmd_region_decode
   import mmd_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          VID_OFS_W = 6,
   parameter int          SND_OFS_W = 8,
   parameter int          COL_OFS_W = 10,
   parameter int          PER_OFS_W = 4,
   parameter int          OFS_W     = 10,
   parameter logic [15:0] BANK_ADDR = 16'h0001
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  vis_t              vis,
   output tgt_e              tgt,
   output logic [OFS_W-1:0]  ofs
);
   generate
      if (ADDR_W != 16) begin : g_bad_a
         $error("mmd_region_decode: map is laid out for a 16-bit bus");
      end
      if (VID_OFS_W > 10 || SND_OFS_W > 10 || COL_OFS_W > 10 || PER_OFS_W > 8) begin : g_bad_ofs
         $error("mmd_region_decode: mirror width exceeds its window");
      end
   endgenerate

   logic in_dxxx, in_axxx, in_exxx;
   assign in_dxxx = (addr[15:12] == 4'hD);
   assign in_axxx = (addr[15:13] == 3'b101);
   assign in_exxx = (addr[15:13] == 3'b111);

   always_comb begin
      tgt = TG_RAM;
      ofs = '0;
      if (addr == BANK_ADDR) begin
         tgt = TG_BREG;
      end else if (vis.io && in_dxxx) begin
         unique case (addr[11:10])
            2'd0: begin tgt = TG_VID; ofs = OFS_W'(addr[VID_OFS_W-1:0]); end
            2'd1: begin tgt = TG_SND; ofs = OFS_W'(addr[SND_OFS_W-1:0]); end
            2'd2: begin tgt = TG_COL; ofs = OFS_W'(addr[COL_OFS_W-1:0]); end
            default: begin
               unique case (addr[9:8])
                  2'd0:    begin tgt = TG_PA; ofs = OFS_W'(addr[PER_OFS_W-1:0]); end
                  2'd1:    begin tgt = TG_PB; ofs = OFS_W'(addr[PER_OFS_W-1:0]); end
                  default: tgt = TG_OPEN;
               endcase
            end
         endcase
      end else if (!wr_en) begin
         if (vis.basic && in_axxx)      tgt = TG_BASIC;
         else if (vis.sys && in_exxx)   tgt = TG_SYS;
         else if (vis.chr && in_dxxx)   tgt = TG_CHR;
      end
   end
endmodule

// File: rtl/mmd_rdata_mux.sv
module mmd_rdata_mux
   import mmd_pkg::*;
#(
   parameter int N      = NUM_TGT,
   parameter int DATA_W = 8
) (
   input  logic [N-1:0]             sel,
   input  logic [N-1:0][DATA_W-1:0] din,
   output logic [DATA_W-1:0]        dout
);
   logic [N:0][DATA_W-1:0] acc;
   assign acc[0] = '0;
   generate
      for (genvar i = 0; i < N; i++) begin : g_leg
         assign acc[i+1] = acc[i] | ({DATA_W{sel[i]}} & din[i]);
      end
   endgenerate
   assign dout = acc[N];
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
   import mmd_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int          VID_OFS_W = 6,
   parameter int          SND_OFS_W = 8,
   parameter int          COL_OFS_W = 10,
   parameter int          PER_OFS_W = 4,
   parameter logic [15:0] BANK_ADDR = 16'h0001,
   parameter logic [7:0]  RESET_VAL = 8'h37
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [DATA_W-1:0]  ram_rdata,
   input  logic [DATA_W-1:0]  basic_rdata,
   input  logic [DATA_W-1:0]  sysrom_rdata,
   input  logic [DATA_W-1:0]  chrom_rdata,
   input  logic [DATA_W-1:0]  video_rdata,
   input  logic [DATA_W-1:0]  sound_rdata,
   input  logic [DATA_W-1:0]  color_rdata,
   input  logic [DATA_W-1:0]  pera_rdata,
   input  logic [DATA_W-1:0]  perb_rdata,
   output logic [10:0]        sel,
   output logic [9:0]         reg_ofs,
   output logic [DATA_W-1:0]  rdata
);
   localparam int OFS_W = 10;

   vis_t                         vis;
   tgt_e                         tgt;
   logic [DATA_W-1:0]            bank_q;
   logic [NUM_TGT-1:0][DATA_W-1:0] din;

   mmd_bank_reg #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_en && (addr == BANK_ADDR)),
      .wr_data(wr_data), .q(bank_q), .vis(vis)
   );

   mmd_region_decode #(
      .ADDR_W(ADDR_W), .VID_OFS_W(VID_OFS_W), .SND_OFS_W(SND_OFS_W),
      .COL_OFS_W(COL_OFS_W), .PER_OFS_W(PER_OFS_W), .OFS_W(OFS_W),
      .BANK_ADDR(BANK_ADDR)
   ) u_dec (
      .addr(addr), .wr_en(wr_en), .vis(vis), .tgt(tgt), .ofs(reg_ofs)
   );

   always_comb begin
      sel = '0;
      sel[tgt] = 1'b1;
   end

   assign din[TG_RAM]   = ram_rdata;
   assign din[TG_BASIC] = basic_rdata;
   assign din[TG_SYS]   = sysrom_rdata;
   assign din[TG_CHR]   = chrom_rdata;
   assign din[TG_VID]   = video_rdata;
   assign din[TG_SND]   = sound_rdata;
   assign din[TG_COL]   = color_rdata;
   assign din[TG_PA]    = pera_rdata;
   assign din[TG_PB]    = perb_rdata;
   assign din[TG_BREG]  = bank_q;
   assign din[TG_OPEN]  = '1;

   mmd_rdata_mux #(.N(NUM_TGT), .DATA_W(DATA_W)) u_mux (
      .sel(sel), .din(din), .dout(rdata)
   );

   // R12: one responder per access
   p_onehot_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel) == 1);

   // R11: a stored banking byte reads back on the next cycle
   p_bank_readback_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en && addr == BANK_ADDR) && !wr_en && addr == BANK_ADDR)
      |-> rdata == $past(wr_data));

   // R10: writes in the ROM ranges never reach a ROM
   p_no_rom_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !(sel[1] || sel[2] || sel[3]));

   // R9: the unused I/O range floats high
   p_open_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sel[10] |-> (rdata == '1 && addr[15:9] == 7'b1101111));

   // R2: codes 0 and 4 leave only RAM and the banking register
   p_all_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_q[1:0] == 2'b00 && addr != BANK_ADDR) |-> sel[0]);
endmodule

// File: tb/sim_mem_map_decoder.sv
module sim_mem_map_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [8:0][7:0] tin;
   logic [10:0] sel;
   logic [9:0]  reg_ofs;
   logic [7:0]  rdata;

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] m_bank = 8'h37;
   bit done = 0;

   always #5 clk = ~clk;

   mem_map_decoder u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .ram_rdata(tin[0]), .basic_rdata(tin[1]), .sysrom_rdata(tin[2]),
      .chrom_rdata(tin[3]), .video_rdata(tin[4]), .sound_rdata(tin[5]),
      .color_rdata(tin[6]), .pera_rdata(tin[7]), .perb_rdata(tin[8]),
      .sel(sel), .reg_ofs(reg_ofs), .rdata(rdata)
   );

   function automatic int exp_tgt(input logic [15:0] a, input bit w, input logic [2:0] c);
      bit io  = (c == 5 || c == 6 || c == 7);
      bit bas = (c == 3 || c == 7);
      bit sys = (c == 2 || c == 3 || c == 6 || c == 7);
      bit chr = (c == 1 || c == 2 || c == 3);
      if (a == 16'h0001) return 9;
      if (io && a >= 16'hD000 && a <= 16'hDFFF) begin
         if (a < 16'hD400) return 4;
         if (a < 16'hD800) return 5;
         if (a < 16'hDC00) return 6;
         if (a < 16'hDD00) return 7;
         if (a < 16'hDE00) return 8;
         return 10;
      end
      if (w) return 0;
      if (bas && a >= 16'hA000 && a <= 16'hBFFF) return 1;
      if (sys && a >= 16'hE000) return 2;
      if (chr && a >= 16'hD000 && a <= 16'hDFFF) return 3;
      return 0;
   endfunction

   function automatic logic [9:0] exp_ofs(input int t, input logic [15:0] a);
      case (t)
         4: return {4'd0, a[5:0]};
         5: return {2'd0, a[7:0]};
         6: return a[9:0];
         7, 8: return {6'd0, a[3:0]};
         default: return 10'd0;
      endcase
   endfunction

   function automatic string req_of(input int t);
      case (t)
         0: return "R2/R10";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         5, 6: return "R7";
         7, 8: return "R8";
         9: return "R11";
         default: return "R9";
      endcase
   endfunction

   task automatic apply(input logic [15:0] a, input bit w, input logic [7:0] d);
      int t;
      logic [7:0] er;
      @(negedge clk);
      addr = a; wr_en = w; wr_data = d;
      for (int i = 0; i < 9; i++) tin[i] = 8'($urandom);
      #1;
      t = exp_tgt(a, w, m_bank[2:0]);
      er = (t == 9) ? m_bank : (t == 10) ? 8'hFF : tin[t];
      n_vec++;
      if (sel != (11'd1 << t) || reg_ofs != exp_ofs(t, a) || (!w && rdata != er)) begin
         n_bad++;
         $display("FAIL %s R12 addr=%h w=%0d code=%0d sel=%b/%b ofs=%h/%h rdata=%h/%h",
                  req_of(t), a, w, m_bank[2:0], sel, 11'd1 << t, reg_ofs, exp_ofs(t, a),
                  rdata, er);
      end
      if (w && a == 16'h0001) m_bank = d;
   endtask

   function automatic logic [15:0] pick_addr();
      int k = $urandom_range(0, 9);
      case (k)
         0: return 16'h0001;
         1: return 16'hA000 + 16'($urandom_range(0, 16'h1FFF));
         2: return 16'hE000 + 16'($urandom_range(0, 16'h1FFF));
         3: return 16'hD000 + 16'($urandom_range(0, 16'h03FF));
         4: return 16'hD400 + 16'($urandom_range(0, 16'h03FF));
         5: return 16'hD800 + 16'($urandom_range(0, 16'h03FF));
         6: return 16'hDC00 + 16'($urandom_range(0, 16'h01FF));
         7: return 16'hDE00 + 16'($urandom_range(0, 16'h01FF));
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      #1500000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250215));
      tin = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1: reset value readback and code-7 map
      apply(16'h0001, 0, 0);
      apply(16'hA123, 0, 0);
      apply(16'hD020, 0, 0);
      apply(16'hFFFC, 0, 0);
      // directed sweep of all codes, R2..R11
      for (int c = 0; c < 8; c++) begin
         apply(16'h0001, 1, 8'hF0 | 8'(c));
         apply(16'h0001, 0, 0);
         apply(16'hBFFF, 0, 0);
         apply(16'hBFFF, 1, 8'h5A);
         apply(16'hE000, 0, 0);
         apply(16'hFFFF, 1, 8'h00);
         apply(16'hD3FF, 0, 0);
         apply(16'hD07F, 1, 8'h01);
         apply(16'hD5C3, 0, 0);
         apply(16'hDBFF, 0, 0);
         apply(16'hDCF7, 0, 0);
         apply(16'hDD1E, 1, 8'h02);
         apply(16'hDE00, 0, 0);
         apply(16'hDFFF, 1, 8'h03);
         apply(16'h0000, 0, 0);
         apply(16'h9FFF, 0, 0);
      end
      // random mix with frequent banking changes
      for (int n = 0; n < 6000; n++) begin
         if ($urandom_range(0, 7) == 0)
            apply(16'h0001, 1, 8'($urandom));
         else
            apply(pick_addr(), bit'($urandom_range(0, 1)), 8'($urandom));
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule